// File: doc/BRIEF.md
# Transmit Byte Buffer and Bit Serializer

This block sits between a host and a bit-level modulator. The host loads outgoing bytes into a 256-entry byte buffer. Each write carries a fixed block of four bytes. A serializer takes bytes out of the buffer and presents them one bit at a time. It moves on by one bit at each bit-rate strobe, and strobes run only while transmit is enabled. The block makes its own strobes by dividing the system clock. A 2-bit rate field picks the divisor for one of two bit rates.

The block sends only what the host wrote, preamble included, and adds no bits of its own. The host can fill the buffer while transmit is disabled, so a burst starts from a full buffer. A ready output tells the host when a whole block fits. Sticky flags report three events: a rejected write, a starved serializer, and the normal end of a burst that the host has marked as its last.

Top module: `tx_byte_serializer`

## Requirements
- R1: After reset, `wr_ready` is 1, `overflow`, `underflow`, `last_done`, `bit_stb` and `tx_bit` are 0, and the buffer is empty.
- R2: An accepted write stores four bytes. The byte on `wr_data[31:24]` is sent first and the byte on `wr_data[7:0]` last. Each byte leaves most significant bit first, and bytes leave in the order they were written.
- R3: The buffer holds 256 bytes. `wr_ready` is 1 exactly when at least 4 byte slots are free, so it falls after the 64th write into an empty buffer and the 63rd write leaves it high.
- R4: A write while `wr_ready` is 0 stores nothing and sets `overflow` on the next cycle. `overflow` stays set until `flag_clr`.
- R5: While `tx_en` is 0 no strobe is produced and no byte leaves the buffer, so the buffer can be preloaded.
- R6: With `rate_sel` = 2'b01, `bit_stb` pulses once every CLK_HZ/9600 clock cycles. With `rate_sel` = 2'b00, 2'b10 or 2'b11 it pulses once every CLK_HZ/1200 cycles.
- R7: At a byte boundary with an empty buffer and no last-data mark, `underflow` is set and stays set until `flag_clr`. While `underflow` is set, every strobe outputs a 0 bit and no byte is taken from the buffer.
- R8: After a `last_set` pulse, the first byte boundary that finds the buffer empty sets `last_done` instead of `underflow`. `last_done` stays set until `flag_clr`, and the strobes from then on output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host block write strobe |
| wr_data | input | 32 | Four bytes, first-sent byte in [31:24] |
| rate_sel | input | 2 | 2'b01 selects the fast rate, any other value the slow rate |
| tx_en | input | 1 | Enables strobes and serialization |
| last_set | input | 1 | Pulse marking that the host's final data is loaded |
| flag_clr | input | 1 | Clears overflow, underflow and last_done |
| wr_ready | output | 1 | A full 4-byte block fits in the buffer |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: serializer starved |
| last_done | output | 1 | Sticky: marked burst fully sent |
| bit_stb | output | 1 | One-cycle pulse, a new `tx_bit` is valid |
| tx_bit | output | 1 | Serial data bit |

## Verification
Buffer pointer or count faults appear at `tx_bit` as wrong, repeated or missing bits. They show up within a byte time of the damaged entry reaching the serializer. A count error also moves the cycle in which `wr_ready` falls during preload away from the 64th write. A bad divider shows as a wrong strobe spacing within two strobe periods of the rate change. Serializer flag faults show as a late or missing `underflow` or `last_done`, or as data bits leaking out while starved.

// File: rtl/tx_buf_pkg.sv
package tx_buf_pkg;
    localparam int BYTE_W = 8;
    localparam logic [1:0] RATE_CODE_FAST = 2'b01;

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [3:0]        left;
        logic              bit_o;
        logic              stb;
        logic              uf;
        logic              lpend;
        logic              ldone;
    } ser_state_t;
endpackage

// File: rtl/txb_rate_gen.sv
module txb_rate_gen #(
    parameter int DIV_SLOW = 20000,
    parameter int DIV_FAST = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       stb
);
    import tx_buf_pkg::*;

    localparam int CW = $clog2(DIV_SLOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stb;
    } rg_t;

    rg_t q, d;
    logic [CW-1:0] lim;

    always_comb begin
        lim = (rate_sel == RATE_CODE_FAST) ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
        d = q;
        d.stb = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (q.cnt >= lim) begin
            d.cnt = '0;
            d.stb = 1'b1;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stb = q.stb;
endmodule

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int DEPTH = 256,
    parameter int BLOCK = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [BLOCK*8-1:0] push_data,
    input  logic               pop,
    output logic [7:0]         rd_byte,
    output logic               empty,
    output logic               space_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [7:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push) d.wp = q.wp + AW'(BLOCK);
        if (pop)  d.rp = q.rp + AW'(1);
        d.cnt = q.cnt + (push ? CW'(BLOCK) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            for (int i = 0; i < BLOCK; i++) begin
                mem[q.wp + AW'(i)] <= push_data[(BLOCK-1-i)*8 +: 8];
            end
        end
    end

    assign rd_byte  = mem[q.rp];
    assign empty    = (q.cnt == '0);
    assign space_ok = (CW'(DEPTH) - q.cnt) >= CW'(BLOCK);
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_in,
    input  logic       buf_empty,
    input  logic [7:0] buf_byte,
    input  logic       last_set,
    input  logic       flag_clr,
    output logic       pop,
    output logic       bit_stb,
    output logic       tx_bit,
    output logic       underflow,
    output logic       last_done
);
    import tx_buf_pkg::*;

    ser_state_t q, d;

    always_comb begin
        d = q;
        d.stb = 1'b0;
        pop = 1'b0;
        if (flag_clr) begin
            d.uf = 1'b0;
            d.ldone = 1'b0;
        end
        if (last_set) d.lpend = 1'b1;
        if (stb_in) begin
            d.stb = 1'b1;
            if (q.left != 4'd0) begin
                d.bit_o = q.shreg[BYTE_W-1];
                d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                d.left  = q.left - 4'd1;
            end else if (q.uf) begin
                d.bit_o = 1'b0;
            end else if (!buf_empty) begin
                pop     = 1'b1;
                d.bit_o = buf_byte[BYTE_W-1];
                d.shreg = {buf_byte[BYTE_W-2:0], 1'b0};
                d.left  = 4'(BYTE_W - 1);
            end else begin
                d.bit_o = 1'b0;
                if (q.lpend || last_set || q.ldone) begin
                    d.ldone = 1'b1;
                    d.lpend = 1'b0;
                end else begin
                    d.uf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_stb   = q.stb;
    assign tx_bit    = q.bit_o;
    assign underflow = q.uf;
    assign last_done = q.ldone;
endmodule

// File: rtl/tx_byte_serializer.sv
module tx_byte_serializer #(
    parameter int CLK_HZ   = 24_000_000,
    parameter int SLOW_BPS = 1200,
    parameter int FAST_BPS = 9600,
    parameter int DEPTH    = 256,
    parameter int BLOCK    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BLOCK*8-1:0] wr_data,
    input  logic [1:0]         rate_sel,
    input  logic               tx_en,
    input  logic               last_set,
    input  logic               flag_clr,
    output logic               wr_ready,
    output logic               overflow,
    output logic               underflow,
    output logic               last_done,
    output logic               bit_stb,
    output logic               tx_bit
);
    localparam int DIV_SLOW = CLK_HZ / SLOW_BPS;
    localparam int DIV_FAST = CLK_HZ / FAST_BPS;

    typedef struct packed {
        logic ovf;
    } top_t;

    top_t q, d;
    logic       space_ok, accept, buf_empty, pop, rate_stb;
    logic [7:0] buf_byte;

    assign accept = wr_en && space_ok;

    always_comb begin
        d = q;
        if (flag_clr)            d.ovf = 1'b0;
        if (wr_en && !space_ok)  d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    txb_rate_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_rate (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .rate_sel(rate_sel), .stb(rate_stb)
    );

    txb_fifo #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_data(wr_data),
        .pop(pop), .rd_byte(buf_byte), .empty(buf_empty), .space_ok(space_ok)
    );

    txb_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .stb_in(rate_stb), .buf_empty(buf_empty),
        .buf_byte(buf_byte), .last_set(last_set), .flag_clr(flag_clr),
        .pop(pop), .bit_stb(bit_stb), .tx_bit(tx_bit),
        .underflow(underflow), .last_done(last_done)
    );

    assign wr_ready = space_ok;
    assign overflow = q.ovf;
endmodule

// File: rtl/txb_checker.sv
module txb_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_ready,
    input logic tx_en,
    input logic flag_clr,
    input logic overflow,
    input logic underflow,
    input logic last_done,
    input logic bit_stb,
    input logic tx_bit
);
    assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> overflow);

    assert_overflow_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flag_clr) |=> overflow);

    assert_no_stb_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(tx_en, 2));

    assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    assert_starved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && bit_stb) |-> !tx_bit);

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flag_clr) |=> underflow);

    assert_last_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_done && !flag_clr) |=> last_done);

    assert_last_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_done && bit_stb) |-> !tx_bit);
endmodule

bind tx_byte_serializer txb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready), .tx_en(tx_en),
    .flag_clr(flag_clr), .overflow(overflow), .underflow(underflow),
    .last_done(last_done), .bit_stb(bit_stb), .tx_bit(tx_bit)
);

// File: tb/tx_byte_serializer_bench.sv
module tx_byte_serializer_bench;
    localparam int CLK_HZ = 19200;
    localparam int DIV_S  = CLK_HZ / 1200;
    localparam int DIV_F  = CLK_HZ / 9600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rate_sel = 2'b00;
    logic        tx_en = 1'b0;
    logic        last_set = 1'b0;
    logic        flag_clr = 1'b0;
    logic        wr_ready, overflow, underflow, last_done, bit_stb, tx_bit;

    int n_tests = 0;
    int n_fail  = 0;
    int stb_seen = 0;
    bit exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_byte_serializer #(.CLK_HZ(CLK_HZ)) u_tx_byte_serializer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rate_sel(rate_sel), .tx_en(tx_en), .last_set(last_set),
        .flag_clr(flag_clr), .wr_ready(wr_ready), .overflow(overflow),
        .underflow(underflow), .last_done(last_done), .bit_stb(bit_stb),
        .tx_bit(tx_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int k);
        logic [7:0] b = 8'(k);
        return {b, ~b, 8'h5A ^ b, b * 8'd3};
    endfunction

    task automatic push_bits(input logic [31:0] d);
        for (int i = 31; i >= 0; i--) exp_q.push_back(d[i]);
    endtask

    // Driver: a tracked write also records its bits in the scoreboard.
    task automatic write_block(input logic [31:0] d, input bit track);
        if (track) push_bits(d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic measure(output int p);
        for (int r = 0; r < 2; r++) begin
            do @(negedge clk); while (!bit_stb);
        end
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!bit_stb);
    endtask

    task automatic wait_high(ref logic sig, input int limit);
        for (int i = 0; i < limit && !sig; i++) @(negedge clk);
    endtask

    // Monitor: every strobe pops the next expected bit (0 when none is queued).
    always @(negedge clk) begin
        if (rst_n && bit_stb) begin
            bit e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            stb_seen++;
            check(tx_bit == e, "R2", "serial bit", tx_bit, e);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        int held_stb;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_ready == 1'b1, "R1", "wr_ready", wr_ready, 1);
        check(overflow == 1'b0, "R1", "overflow", overflow, 0);
        check(underflow == 1'b0, "R1", "underflow", underflow, 0);
        check(last_done == 1'b0, "R1", "last_done", last_done, 0);
        check(bit_stb == 1'b0 && tx_bit == 1'b0, "R1", "bit_stb/tx_bit", {bit_stb, tx_bit}, 0);

        // R3/R5 preload with tx disabled
        for (int k = 0; k < 63; k++) write_block(pattern(k), 1'b1);
        check(wr_ready == 1'b1, "R3", "ready after 63 writes", wr_ready, 1);
        write_block(pattern(63), 1'b1);
        check(wr_ready == 1'b0, "R3", "ready after 64 writes", wr_ready, 0);
        repeat (50) @(negedge clk);
        check(stb_seen == 0, "R5", "strobes while disabled", stb_seen, 0);
        check(wr_ready == 1'b0, "R5", "buffer kept full", wr_ready, 0);

        // R4 dropped write
        write_block(32'hDEADBEEF, 1'b0);
        check(overflow == 1'b1, "R4", "overflow set", overflow, 1);
        repeat (5) @(negedge clk);
        check(overflow == 1'b1, "R4", "overflow sticky", overflow, 1);
        pulse_clr();
        check(overflow == 1'b0, "R4", "overflow cleared", overflow, 0);

        // R6 rates, while streaming the preloaded data (R2)
        rate_sel = 2'b00;
        tx_en = 1'b1;
        measure(p);
        check(p == DIV_S, "R6", "period code 00", p, DIV_S);
        rate_sel = 2'b10;
        measure(p);
        check(p == DIV_S, "R6", "period code 10", p, DIV_S);
        rate_sel = 2'b11;
        measure(p);
        check(p == DIV_S, "R6", "period code 11", p, DIV_S);
        rate_sel = 2'b01;
        measure(p);
        check(p == DIV_F, "R6", "period code 01", p, DIV_F);

        // R8 last-data completion
        @(negedge clk);
        last_set = 1'b1;
        @(negedge clk);
        last_set = 1'b0;
        wait_high(last_done, 20000);
        check(last_done == 1'b1, "R8", "last_done", last_done, 1);
        check(underflow == 1'b0, "R8", "no underflow at end", underflow, 0);
        check(exp_q.size() == 0, "R2", "all bits delivered", exp_q.size(), 0);
        check(wr_ready == 1'b1, "R3", "ready after drain", wr_ready, 1);
        repeat (10) @(negedge clk);
        check(last_done == 1'b1, "R8", "last_done sticky", last_done, 1);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clr();
        check(last_done == 1'b0, "R8", "last_done cleared", last_done, 0);

        // R7 underflow
        write_block(pattern(100), 1'b1);
        write_block(pattern(101), 1'b1);
        tx_en = 1'b1;
        wait_high(underflow, 2000);
        check(underflow == 1'b1, "R7", "underflow set", underflow, 1);
        check(exp_q.size() == 0, "R7", "data before starve sent", exp_q.size(), 0);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);
        held = pattern(200);
        write_block(held, 1'b0);
        held_stb = stb_seen;
        tx_en = 1'b1;
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        check(stb_seen - held_stb >= 40, "R7", "zero strobes while starved", stb_seen - held_stb, 40);
        check(underflow == 1'b1, "R7", "underflow sticky", underflow, 1);
        repeat (4) @(negedge clk);
        push_bits(held);
        pulse_clr();
        check(underflow == 1'b0, "R7", "underflow cleared", underflow, 0);
        tx_en = 1'b1;
        wait_high(underflow, 2000);
        check(exp_q.size() == 0, "R7", "held block kept and sent", exp_q.size(), 0);
        tx_en = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule